// File: doc/BRIEF.md
# Effective-Address Front End for General-Format Instructions

This block takes the leading byte of a general-format instruction and works out how its operand is reached. From that byte it derives an addressing mode, an operand size (byte or word), a register number and the number of bytes the addressing part occupies. For the register-based modes it reads the selected register from a flat register-file input and forms the effective address. Where a mode adjusts its base register, it also issues a register writeback. Immediate and absolute forms take their operand from the one or two bytes that follow the leading byte, and multi-byte quantities in those bytes are big-endian.

Requests enter through a valid/ready pair and results leave through a second valid/ready pair, with one register stage between them. An upstream request is taken on a clock edge where `in_valid` and `in_ready` are both high. The result appears on the following cycle with `out_valid` high. While `out_valid` is high and `out_ready` is low, the result is held unchanged and `in_ready` stays low, so back-pressure reaches the issuing stage within the same cycle. The register writeback strobe is a single-cycle pulse that the register file must take unconditionally. Opcode execution and memory access belong to other blocks.

Top module: `ea_unit`

## Requirements
- R1: The leading bytes 0xA0-0xFF select the mode from the upper nibble. 0xA gives register direct (mode code 0), 0xB pre-decrement (1), 0xC post-increment (2), 0xD register indirect (3), 0xE register plus 8-bit displacement (4) and 0xF register plus 16-bit displacement (5). Bits 2:0 give the register number, and bit 3 set selects word size (`out_word`=1).
- R2: The reported length is 1 for 0xA0-0xDF, 2 for 0xE0-0xEF and 0x04, and 3 for 0xF0-0xFF, 0x0C, 0x15 and 0x1D.
- R3: 0x04 is a byte immediate (mode 6) whose value is the first following byte, zero-extended. 0x0C is a word immediate (mode 6) with a big-endian value. 0x15 (byte) and 0x1D (word) are absolute forms (mode 7) whose value is the big-endian 16-bit address. `in_ext[15:8]` carries the first following byte, and `out_reg` is 0 for modes 6 and 7.
- R4: Register direct yields the register contents, with byte size giving the low 8 bits zero-extended. Register indirect yields the register as the address. The displacement modes yield the register plus the sign-extended 8-bit displacement, or plus the 16-bit displacement, modulo 2^16.
- R5: Pre-decrement yields the register minus the size (1 or 2) modulo 2^16 as the address, and writes that same value back to the register.
- R6: Post-increment yields the unmodified register as the address. On a read access (`in_is_write`=0) it writes the register plus the size, modulo 2^16, back to the register. On a write access it issues no writeback.
- R7: Any other leading byte raises `out_illegal` and reports mode 0, length 1, value 0, register 0 and byte size, with no writeback.
- R8: `wb_en` pulses for exactly one cycle, the first cycle of the result it belongs to, and only for pre-decrement and read-access post-increment.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every result output stays stable. `out_valid` falls after a taken result when no new request was accepted.
- R10: During and right after reset, `out_valid` and `wb_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be taken this cycle |
| in_prefix | input | 8 | Leading byte of the instruction |
| in_ext | input | 16 | Following bytes, first byte in [15:8] |
| in_is_write | input | 1 | 1 = operand will be written, 0 = read |
| rf_flat | input | 128 | Register file, register i in [16i+15:16i] |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream takes the result |
| out_mode | output | 3 | Mode code (see R1, R3) |
| out_word | output | 1 | Operand size is word |
| out_reg | output | 3 | Register number |
| out_len | output | 2 | Length of addressing bytes |
| out_value | output | 16 | Effective address, register value or immediate |
| out_illegal | output | 1 | Leading byte not recognised |
| wb_en | output | 1 | Register writeback strobe |
| wb_reg | output | 3 | Register to write |
| wb_data | output | 16 | Value to write |

## Verification
On every cycle, the assertions check the handshake rules of R9, the reset state of R10, and the rule that a writeback strobe follows only an accepted pre-decrement or read-side post-increment (R5, R6, R8). They also check that an illegal result never carries a writeback (R7), and that a post-increment with a write access stays silent. The actual arithmetic is shown only by the bench's scenarios, which compare every output against a behavioural model under random back-pressure. That arithmetic covers the wrap at 0x0000 and 0xFFFF, negative displacements, big-endian byte order and byte/word selection. The scenarios exercise every leading-byte range, both access kinds and a spread of illegal bytes.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int AW = 16;
  localparam int NREG = 8;
  localparam int RIDX_W = $clog2(NREG);

  typedef enum logic [2:0] {
    M_REG    = 3'd0,
    M_PREDEC = 3'd1,
    M_POSTINC= 3'd2,
    M_INDIR  = 3'd3,
    M_DISP8  = 3'd4,
    M_DISP16 = 3'd5,
    M_IMM    = 3'd6,
    M_ABS    = 3'd7
  } mode_e;

  typedef struct packed {
    mode_e             mode;
    logic              word;
    logic [RIDX_W-1:0] regno;
    logic [1:0]        len;
    logic              illegal;
    logic              uses_reg;
  } dec_t;

  typedef struct packed {
    mode_e             mode;
    logic              word;
    logic [RIDX_W-1:0] regno;
    logic [1:0]        len;
    logic [AW-1:0]     value;
    logic              illegal;
  } res_t;
endpackage

// File: rtl/ea_prefix_decode.sv
module ea_prefix_decode
  import ea_pkg::*;
(
  input  logic [7:0] prefix,
  output dec_t       dec
);
  always_comb begin
    dec          = '0;
    dec.mode     = M_REG;
    dec.len      = 2'd1;
    dec.illegal  = 1'b0;
    dec.uses_reg = 1'b0;
    if (prefix[7:4] >= 4'hA) begin
      dec.uses_reg = 1'b1;
      dec.word     = prefix[3];
      dec.regno    = prefix[RIDX_W-1:0];
      unique case (prefix[7:4])
        4'hA: begin dec.mode = M_REG;     dec.len = 2'd1; end
        4'hB: begin dec.mode = M_PREDEC;  dec.len = 2'd1; end
        4'hC: begin dec.mode = M_POSTINC; dec.len = 2'd1; end
        4'hD: begin dec.mode = M_INDIR;   dec.len = 2'd1; end
        4'hE: begin dec.mode = M_DISP8;   dec.len = 2'd2; end
        default: begin dec.mode = M_DISP16; dec.len = 2'd3; end
      endcase
    end else begin
      unique case (prefix)
        8'h04: begin dec.mode = M_IMM; dec.word = 1'b0; dec.len = 2'd2; end
        8'h0C: begin dec.mode = M_IMM; dec.word = 1'b1; dec.len = 2'd3; end
        8'h15: begin dec.mode = M_ABS; dec.word = 1'b0; dec.len = 2'd3; end
        8'h1D: begin dec.mode = M_ABS; dec.word = 1'b1; dec.len = 2'd3; end
        default: dec.illegal = 1'b1;
      endcase
    end
  end

  always_comb begin
    if (dec.illegal)
      a_r7_illegal_shape: assert (dec.len == 2'd1 && !dec.uses_reg && dec.mode == M_REG);
  end
endmodule

// File: rtl/ea_reg_select.sv
module ea_reg_select
  import ea_pkg::*;
#(
  parameter int N = NREG,
  parameter int W = AW,
  localparam int IW = $clog2(N)
)(
  input  logic [N*W-1:0] rf_flat,
  input  logic [IW-1:0]  idx,
  output logic [W-1:0]   q
);
  logic [W-1:0] regs [N];
  for (genvar i = 0; i < N; i++) begin : g_unpack
    assign regs[i] = rf_flat[i*W +: W];
  end
  assign q = regs[idx];
endmodule

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
  import ea_pkg::*;
(
  input  dec_t              dec,
  input  logic [AW-1:0]     ext,
  input  logic [AW-1:0]     base,
  input  logic              is_write,
  output logic [AW-1:0]     value,
  output logic              wb_req,
  output logic [AW-1:0]     wb_val
);
  logic [AW-1:0] step;
  logic [AW-1:0] d8_sext;
  logic [AW-1:0] dec_val;
  logic [AW-1:0] inc_val;

  assign step    = dec.word ? AW'(2) : AW'(1);
  assign d8_sext = {{(AW-8){ext[AW-1]}}, ext[AW-1 -: 8]};
  assign dec_val = base - step;
  assign inc_val = base + step;

  always_comb begin
    value  = '0;
    wb_req = 1'b0;
    wb_val = '0;
    if (!dec.illegal) begin
      unique case (dec.mode)
        M_REG:     value = dec.word ? base : {{(AW-8){1'b0}}, base[7:0]};
        M_PREDEC:  begin value = dec_val; wb_req = 1'b1; wb_val = dec_val; end
        M_POSTINC: begin value = base; wb_req = !is_write; wb_val = inc_val; end
        M_INDIR:   value = base;
        M_DISP8:   value = base + d8_sext;
        M_DISP16:  value = base + ext;
        M_IMM:     value = dec.word ? ext : {{(AW-8){1'b0}}, ext[AW-1 -: 8]};
        default:   value = ext;
      endcase
    end
  end

  always_comb begin
    if (wb_req)
      a_r6_wb_mode: assert (dec.mode == M_PREDEC || (dec.mode == M_POSTINC && !is_write));
  end
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_prefix,
  input  logic [15:0]      in_ext,
  input  logic             in_is_write,
  input  logic [127:0]     rf_flat,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [2:0]       out_mode,
  output logic             out_word,
  output logic [2:0]       out_reg,
  output logic [1:0]       out_len,
  output logic [15:0]      out_value,
  output logic             out_illegal,
  output logic             wb_en,
  output logic [2:0]       wb_reg,
  output logic [15:0]      wb_data
);
  dec_t          dec;
  logic [AW-1:0] base;
  logic [AW-1:0] value;
  logic          wb_req;
  logic [AW-1:0] wb_val;
  logic          accept;
  res_t          res_q;

  ea_prefix_decode u_dec (.prefix(in_prefix), .dec(dec));

  ea_reg_select #(.N(NREG), .W(AW)) u_sel (
    .rf_flat(rf_flat), .idx(dec.regno), .q(base));

  ea_addr_gen u_gen (
    .dec(dec), .ext(in_ext), .base(base), .is_write(in_is_write),
    .value(value), .wb_req(wb_req), .wb_val(wb_val));

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
      wb_reg    <= '0;
      wb_data   <= '0;
      res_q     <= '0;
    end else begin
      wb_en <= 1'b0;
      if (accept) begin
        out_valid     <= 1'b1;
        res_q.mode    <= dec.mode;
        res_q.word    <= dec.word;
        res_q.regno   <= dec.regno;
        res_q.len     <= dec.len;
        res_q.value   <= value;
        res_q.illegal <= dec.illegal;
        wb_en         <= wb_req;
        wb_reg        <= dec.regno;
        wb_data       <= wb_val;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign out_mode    = res_q.mode;
  assign out_word    = res_q.word;
  assign out_reg     = res_q.regno;
  assign out_len     = res_q.len;
  assign out_value   = res_q.value;
  assign out_illegal = res_q.illegal;

  a_r10_reset_clear: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !wb_en);

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_value) && $stable(out_mode)
      && $stable(out_len) && $stable(out_reg) && $stable(out_word) && $stable(out_illegal));

  a_r9_drain: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  a_r8_wb_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> $past(in_valid && in_ready) && out_valid);

  a_r8_wb_single: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en && !$past(in_valid && in_ready) |-> 1'b0);

  a_r7_no_wb_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> !out_illegal);

  a_r5_predec_wb_match: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en && out_mode == M_PREDEC |-> wb_data == out_value && wb_reg == out_reg);

  a_r6_postinc_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    accept && dec.mode == M_POSTINC && !dec.illegal && in_is_write |=> !wb_en);

  a_r2_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_len != 2'd0);
endmodule

// File: tb/ea_unit_test.sv
`timescale 1ns/1ps
module ea_unit_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [7:0]   in_prefix = '0;
  logic [15:0]  in_ext = '0;
  logic         in_is_write = 1'b0;
  logic [15:0]  rf [8];
  logic [127:0] rf_flat;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [2:0]   out_mode;
  logic         out_word;
  logic [2:0]   out_reg;
  logic [1:0]   out_len;
  logic [15:0]  out_value;
  logic         out_illegal;
  logic         wb_en;
  logic [2:0]   wb_reg;
  logic [15:0]  wb_data;

  always #2.5 clk = ~clk;

  always_comb for (int i = 0; i < 8; i++) rf_flat[i*16 +: 16] = rf[i];

  ea_unit uut (.*);

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit timed_out = 0;

  // reference model state
  bit m_valid = 0, m_wb = 0, acc_last = 0;
  int m_mode, m_word, m_reg, m_len, m_val, m_ill, m_wbreg, m_wbdat;

  task automatic model(input int p, input int e, input bit wr,
                       output int mode, output int word, output int rg, output int len,
                       output int val, output int ill, output bit wb, output int wbd);
    int b, sz, d;
    mode = 0; word = 0; rg = 0; len = 1; val = 0; ill = 0; wb = 0; wbd = 0;
    if (p >= 'hA0) begin
      rg = p % 8; word = (p / 8) % 2; sz = word ? 2 : 1; b = rf[rg];
      case (p / 16)
        'hA: begin mode = 0; val = word ? b : b % 256; end
        'hB: begin mode = 1; val = (b - sz + 65536) % 65536; wb = 1; wbd = val; end
        'hC: begin mode = 2; val = b; wb = !wr; wbd = (b + sz) % 65536; end
        'hD: begin mode = 3; val = b; end
        'hE: begin mode = 4; len = 2; d = e / 256; if (d >= 128) d -= 256;
                   val = (b + d + 65536) % 65536; end
        default: begin mode = 5; len = 3; val = (b + e) % 65536; end
      endcase
    end else if (p == 'h04) begin mode = 6; len = 2; val = e / 256; end
    else if (p == 'h0C) begin mode = 6; len = 3; word = 1; val = e; end
    else if (p == 'h15) begin mode = 7; len = 3; val = e; end
    else if (p == 'h1D) begin mode = 7; len = 3; word = 1; val = e; end
    else ill = 1;
  endtask

  always @(posedge clk) begin
    bit acc, w;
    int a, b2, c, d, e, f, g;
    if (!rst_n) begin
      m_valid = 0; m_wb = 0; acc_last = 0;
    end else begin
      acc = in_valid && (!m_valid || out_ready);
      m_wb = 0;
      if (acc) begin
        model(in_prefix, in_ext, in_is_write, a, b2, c, d, e, f, w, g);
        m_mode = a; m_word = b2; m_reg = c; m_len = d; m_val = e; m_ill = f;
        m_wb = w; m_wbreg = c; m_wbdat = g; m_valid = 1;
      end else if (out_ready) m_valid = 0;
      acc_last = acc;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (prefix %02h)", tag, act, exp, in_prefix);
    end
  endtask

  function automatic string vtag(int mode);
    case (mode)
      0, 3, 4, 5: return "R4 value";
      1: return "R5 value";
      2: return "R6 value";
      default: return "R3 value";
    endcase
  endfunction

  task automatic compare();
    chk("R9 in_ready", in_ready, !m_valid || out_ready);
    chk("R9 out_valid", out_valid, m_valid);
    chk("R8 wb_en", wb_en, m_wb);
    if (m_wb) begin
      chk("R5 R6 wb_reg", wb_reg, m_wbreg);
      chk("R5 R6 wb_data", wb_data, m_wbdat);
    end
    if (m_valid) begin
      chk("R7 illegal", out_illegal, m_ill);
      chk("R1 mode", out_mode, m_mode);
      chk("R1 word", out_word, m_word);
      chk("R1 reg", out_reg, m_reg);
      chk("R2 len", out_len, m_len);
      chk(vtag(m_mode), out_value, m_val);
    end
  endtask

  localparam int NDIR = 20;
  function automatic int dir_prefix(int i);
    int t [NDIR] = '{'hA3, 'hAB, 'hB5, 'hBD, 'hC2, 'hCA, 'hD7, 'hDF, 'hE1, 'hE9,
                     'hF4, 'hFC, 'h04, 'h0C, 'h15, 'h1D, 'h00, 'h16, 'h9F, 'h05};
    return t[i];
  endfunction

  function automatic int rand_prefix();
    int r = $urandom % 10;
    if (r < 6) return 'hA0 + ($urandom % 96);
    if (r < 9) begin
      int s = $urandom % 4;
      return s == 0 ? 'h04 : s == 1 ? 'h0C : s == 2 ? 'h15 : 'h1D;
    end
    return $urandom % 'hA0;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    timed_out = 1;
  end

  initial begin
    int dir_i = 0;
    for (int i = 0; i < 8; i++) rf[i] = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 out_valid in reset", out_valid, 0);
    chk("R10 wb_en in reset", wb_en, 0);
    rst_n = 1'b1;
    while (cycles < 4000 && !timed_out) begin
      @(negedge clk);
      cycles++;
      compare();
      if (acc_last || !in_valid) begin
        if (dir_i < 2 * NDIR) begin
          // directed: wrap values and both access kinds
          in_prefix   = 8'(dir_prefix(dir_i % NDIR));
          in_is_write = dir_i >= NDIR;
          for (int i = 0; i < 8; i++)
            rf[i] = (i % 4 == 0) ? 16'h0000 : (i % 4 == 1) ? 16'hFFFF :
                    (i % 4 == 2) ? 16'h8001 : 16'h12FE;
          in_ext   = (dir_i % 2) ? 16'h80FF : 16'h7F01;
          in_valid = 1'b1;
          dir_i++;
        end else begin
          in_valid    = ($urandom % 5) != 0;
          in_prefix   = 8'(rand_prefix());
          in_ext      = 16'($urandom);
          in_is_write = $urandom % 2;
          for (int i = 0; i < 8; i++) rf[i] = 16'($urandom);
        end
      end
      out_ready = (cycles < 60) ? 1'b1 : (($urandom % 3) != 0);
      if (cycles == 3000) begin
        in_valid = 1'b0;
      end
    end
    // R9: drain with no new request
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) begin @(negedge clk); compare(); end
    chk("R9 drained", out_valid, 0);
    if (timed_out) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule